// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block sits beside one UART channel and turns its event lines into a single interrupt request. Software programs an 8-bit enable register. The block keeps the enabled conditions that are pending and picks the most urgent one. It publishes that one as a code in a read-only identification byte and raises `irq` while anything enabled is pending.

Some conditions are levels that the receive path drives: data waiting, and receive time-out. The others are one-cycle event pulses, which the block latches. Each latched condition clears through its own read rule. A read of the identification byte clears a reported transmit-empty or flow-control condition. A side-band strobe from the line status read clears a line error. A side-band strobe from the modem status read clears the modem, RTS/DTR and CTS/DSR conditions.

The register port is one byte wide with a one-cycle read latency. Offset 1 holds the enable register and offset 2 holds the identification byte. A read captures its byte at the strobe edge and holds it until the next read, so the value cannot change during an access.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 00h, the identification byte reads C1h with `fifo_on` high, and `irq` is low.
- R2: The enable register stores all 8 written bits, including reserved bit 7. A write to offset 0 (the transmit holding location, which may be full) changes neither the enable register nor any pending condition.
- R3: A condition whose enable bit is 0 is neither reported nor drives `irq`. A latched event stays latched while masked and appears once its enable bit is set. Enable bit mapping: bit0 receive data and time-out, bit1 transmit empty, bit2 line error, bit3 modem, bit4 flow control, bit5 RTS/DTR, bit6 CTS/DSR.
- R4: Bit 0 of the identification byte is 0 when an interrupt is pending and 1 when none is pending. Bits 7:6 read 11 when `fifo_on` is high and 00 when it is low.
- R5: The sources rank from highest to lowest as line error, receive data, receive time-out, transmit empty, then modem. Bits 3:0 carry 0110, 0100, 1100, 0010 and 0000 respectively, and 0001 when idle.
- R6: Below modem rank flow control, then RTS/DTR, then CTS/DSR. Bits 5:0 carry 10h, 20h and 00h for these three. Bits 5:4 are 00 for all other codes.
- R7: A read of offset 2 clears a latched transmit-empty or flow-control condition only when that condition is the one reported in the byte returned.
- R8: `lsr_rd` clears the line error condition. `msr_rd` clears the modem, RTS/DTR and CTS/DSR conditions.
- R9: Receive data and receive time-out are not latched. They are pending exactly while their inputs are high.
- R10: `irq` is high exactly when at least one enabled condition is pending.
- R11: `rd_data` is loaded on the clock edge where `rd_en` is high and keeps its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered |
| fifo_on | input | 1 | FIFO mode active, shown in bits 7:6 |
| line_err_evt | input | 1 | Receive line error event pulse |
| rx_ready | input | 1 | Receive data level condition |
| rx_tmo | input | 1 | Receive time-out level condition |
| tx_empty_evt | input | 1 | Transmit empty event pulse |
| modem_evt | input | 1 | Modem status change event pulse |
| flow_evt | input | 1 | Flow-control or special character event pulse |
| rts_evt | input | 1 | RTS/DTR change event pulse |
| cts_evt | input | 1 | CTS/DSR change event pulse |
| lsr_rd | input | 1 | Side-band line status read strobe |
| msr_rd | input | 1 | Side-band modem status read strobe |
| irq | output | 1 | Interrupt request |

## Verification
A latch that fails to clear shows up as the same code on the next read of offset 2 and as `irq` staying high. A latch that fails to set shows up as code 0001 and `irq` low on the read that follows the event pulse. A wrong priority or code shows up on the first read after two sources are pending together, so the bench stacks sources and releases them one at a time. A wrong clear condition on transmit-empty shows up when a higher source masks it during a read and the transmit code later fails to reappear.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          fifo_on,
  input  logic          line_err_evt,
  input  logic          rx_ready,
  input  logic          rx_tmo,
  input  logic          tx_empty_evt,
  input  logic          modem_evt,
  input  logic          flow_evt,
  input  logic          rts_evt,
  input  logic          cts_evt,
  input  logic          lsr_rd,
  input  logic          msr_rd,
  output logic          irq
);
  localparam logic [AW-1:0] A_EN = AW'(1);
  localparam logic [AW-1:0] A_ID = AW'(2);
  localparam logic [5:0] ID_LINE = 6'h06, ID_RX = 6'h04, ID_TMO = 6'h0C,
                         ID_TX = 6'h02, ID_MDM = 6'h00, ID_FLOW = 6'h10,
                         ID_RTS = 6'h20, ID_CTS = 6'h00, ID_NONE = 6'h01;

  logic [7:0] en_q;
  logic line_q, tx_q, mdm_q, flow_q, rts_q, cts_q;
  logic [5:0] id;
  logic [7:0] id_byte;
  logic id_rd;

  assign id_rd = rd_en && addr == A_ID;

  always_comb begin
    if      (en_q[2] && line_q)  id = ID_LINE;
    else if (en_q[0] && rx_ready) id = ID_RX;
    else if (en_q[0] && rx_tmo)   id = ID_TMO;
    else if (en_q[1] && tx_q)    id = ID_TX;
    else if (en_q[3] && mdm_q)   id = ID_MDM;
    else if (en_q[4] && flow_q)  id = ID_FLOW;
    else if (en_q[5] && rts_q)   id = ID_RTS;
    else if (en_q[6] && cts_q)   id = ID_CTS;
    else                         id = ID_NONE;
  end

  assign id_byte = {fifo_on, fifo_on, id};
  assign irq = (en_q[2] & line_q) | (en_q[0] & (rx_ready | rx_tmo)) |
               (en_q[1] & tx_q) | (en_q[3] & mdm_q) | (en_q[4] & flow_q) |
               (en_q[5] & rts_q) | (en_q[6] & cts_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      rd_data <= 8'hC1;
      line_q  <= 1'b0;
      tx_q    <= 1'b0;
      mdm_q   <= 1'b0;
      flow_q  <= 1'b0;
      rts_q   <= 1'b0;
      cts_q   <= 1'b0;
    end else begin
      if (wr_en && addr == A_EN) en_q <= wr_data;
      if (rd_en) rd_data <= (addr == A_EN) ? en_q : (addr == A_ID) ? id_byte : 8'h00;
      line_q <= line_err_evt | (line_q & ~lsr_rd);
      tx_q   <= tx_empty_evt | (tx_q & ~(id_rd && id == ID_TX));
      flow_q <= flow_evt | (flow_q & ~(id_rd && id == ID_FLOW));
      mdm_q  <= modem_evt | (mdm_q & ~msr_rd);
      rts_q  <= rts_evt | (rts_q & ~msr_rd);
      cts_q  <= cts_evt | (cts_q & ~msr_rd);
    end
  end

  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id == ID_TX && !tx_empty_evt) |=> !tx_q);
  // R8
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_err_evt) |=> !line_q);
  // R8
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !modem_evt && !rts_evt && !cts_evt) |=> !(mdm_q | rts_q | cts_q));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R4
  pend_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !id_byte[0]);
  // R3
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h00) |-> !irq);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0, fifo_on = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic line_err_evt = 0, rx_ready = 0, rx_tmo = 0, tx_empty_evt = 0, modem_evt = 0;
  logic flow_evt = 0, rts_evt = 0, cts_evt = 0, lsr_rd = 0, msr_rd = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk("R1 enable", 3'd1, 8'h00);
    rd_chk("R1 ident", 3'd2, 8'hC1);
  endtask

  task automatic t_enable();
    wr(3'd1, 8'hA5);
    rd_chk("R2 enable all bits", 3'd1, 8'hA5);
    wr(3'd0, 8'h3C);
    rd_chk("R2 offset0 write enable", 3'd1, 8'hA5);
    rd_chk("R2 offset0 write ident", 3'd2, 8'hC1);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mask();
    pulse(line_err_evt);
    chk("R3 masked irq", {7'b0, irq}, 8'h00);
    rd_chk("R3 masked ident", 3'd2, 8'hC1);
    wr(3'd1, 8'h04);
    rd_chk("R3 unmasked ident", 3'd2, 8'hC6);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    pulse(lsr_rd);
    rd_chk("R8 line cleared", 3'd2, 8'hC1);
    chk("R10 irq off", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_priority();
    wr(3'd1, 8'hFF);
    @(negedge clk); rx_tmo = 1;
    rd_chk("R9 timeout", 3'd2, 8'hCC);
    @(negedge clk); rx_ready = 1;
    rd_chk("R5 rx over tmo", 3'd2, 8'hC4);
    pulse(line_err_evt);
    rd_chk("R5 line top", 3'd2, 8'hC6);
    pulse(lsr_rd);
    rd_chk("R8 line clear", 3'd2, 8'hC4);
    @(negedge clk); rx_ready = 0;
    rd_chk("R9 rx level drop", 3'd2, 8'hCC);
    @(negedge clk); rx_tmo = 0;
    rd_chk("R9 tmo drop", 3'd2, 8'hC1);
    pulse(tx_empty_evt);
    pulse(modem_evt);
    rd_chk("R5 tx over modem", 3'd2, 8'hC2);
    rd_chk("R7 tx cleared", 3'd2, 8'hC0);
    pulse(msr_rd);
    rd_chk("R8 modem cleared", 3'd2, 8'hC1);
  endtask

  task automatic t_tx_rule();
    pulse(tx_empty_evt);
    @(negedge clk); rx_ready = 1;
    rd_chk("R7 rx hides tx", 3'd2, 8'hC4);
    @(negedge clk); rx_ready = 0;
    rd_chk("R7 tx kept", 3'd2, 8'hC2);
    rd_chk("R7 tx gone", 3'd2, 8'hC1);
  endtask

  task automatic t_extra();
    pulse(cts_evt);
    rd_chk("R6 cts", 3'd2, 8'hC0);
    pulse(rts_evt);
    rd_chk("R6 rts over cts", 3'd2, 8'hE0);
    pulse(flow_evt);
    rd_chk("R6 flow top", 3'd2, 8'hD0);
    rd_chk("R7 flow cleared", 3'd2, 8'hE0);
    pulse(msr_rd);
    rd_chk("R8 rts cts cleared", 3'd2, 8'hC1);
    chk("R10 idle", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_fifo_and_hold();
    @(negedge clk); fifo_on = 0;
    rd_chk("R4 fifo off idle", 3'd2, 8'h01);
    pulse(tx_empty_evt);
    chk("R11 rdata held", rd_data, 8'h01);
    rd_chk("R4 fifo off tx", 3'd2, 8'h02);
    @(negedge clk); fifo_on = 1;
    rd_chk("R4 fifo on idle", 3'd2, 8'hC1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enable();
        t_mask();
        t_priority();
        t_tx_rule();
        t_extra();
        t_fifo_and_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule